// File: doc/BRIEF.md
# Thermal Limit Alert Controller

This block sits behind a temperature converter and decides when a thermal alert line should be driven. Every time a new 12-bit signed temperature result is strobed in, it is compared against a programmable low limit and a programmable high limit. A consecutive-fault counter filters out isolated noisy readings before the alert state changes. The result, the limits and the comparison are all signed two's complement values at 1/16 °C per LSB.

Two behaviours can be chosen. In comparator mode the alert rises once the temperature has reached the high limit often enough in a row. It falls once the temperature has dropped below the low limit the same number of times in a row, so the gap between the limits acts as hysteresis. In interrupt mode the alert latches until software acknowledges it, either by reading any register or by winning an alert-response cycle. After each acknowledge the block switches between watching the high limit and watching the low limit. A cause flag reports which limit raised the alert.

Top module: `thermAlert`

## Requirements
- R1: After hardware reset the alert is inactive, the alert pin shows the inactive level for the selected polarity, and the cause flag is 0.
- R2: The fault-queue code sets how many consecutive qualifying results are needed: code 0 needs 1, code 1 needs 2, code 2 needs 4, code 3 needs 6.
- R3: In comparator mode the alert asserts after the required number of consecutive results at or above the high limit, with the cause flag set to 1. It deasserts after the same number of consecutive results strictly below the low limit. Results between the limits hold the state.
- R4: A result that does not meet the condition currently being watched resets the consecutive-fault count to zero. The count never exceeds 6.
- R5: Only a cycle with the result-valid strobe high performs a comparison. A changing temperature value with no strobe changes nothing.
- R6: In interrupt mode, once the alert has been raised by the high limit (cause 1), it stays active regardless of further results until a register-read strobe or an alert-response-won strobe arrives, which clears it on the next clock edge.
- R7: In interrupt mode, after a clear the block watches for consecutive results below the low limit and asserts with cause 0. After the next clear it watches the high limit again.
- R8: In comparator mode the register-read and alert-response-won strobes have no effect on the alert.
- R9: A shutdown-rising-edge strobe clears the alert and the fault count in both modes. In interrupt mode it also returns the block to watching the high limit.
- R10: A soft reset clears the alert, the fault count and the cause flag, and forces comparator behaviour even while the mode input requests interrupt mode. Interrupt behaviour returns only after the mode input has been seen low for at least one cycle.
- R11: With polarity 0 the alert pin is low when the alert is active. With polarity 1 it is high when active.
- R12: A soft reset or shutdown-rising-edge strobe in the same cycle as a result-valid strobe wins: that result is discarded.
- R13: Comparisons are signed, so a result of 0xFFC (−0.25 °C) lies below a high limit of 0x004 (+0.25 °C).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| resultValid | input | 1 | One-cycle strobe: a new conversion result is on resultTemp |
| resultTemp | input | 12 | Signed temperature result, 1/16 °C per LSB |
| limitLow | input | 12 | Signed low limit |
| limitHigh | input | 12 | Signed high limit |
| faultQueue | input | 2 | Consecutive-fault code (1, 2, 4 or 6 faults) |
| alertPolarity | input | 1 | 0: pin active low, 1: pin active high |
| interruptMode | input | 1 | 0: comparator mode, 1: interrupt mode |
| regRead | input | 1 | Strobe: a register read occurred |
| responseWon | input | 1 | Strobe: an alert-response cycle was won |
| shutdownRise | input | 1 | Strobe: rising edge of the shutdown control |
| softReset | input | 1 | Strobe: soft reset |
| alertPin | output | 1 | Alert output level |
| alertCause | output | 1 | 1 when the last alert came from the high limit, 0 from the low limit |

## Verification
The bench targets the exact threshold of each fault-queue code. A wrong mapping would assert one result early or late. It breaks a run of faults with an in-between reading, which a counter that failed to reset would miss. It also checks that results at or between the limits hold the state, where an off-by-one comparison would flip it. In interrupt mode it walks the high–low watching cycle with both kinds of acknowledge. A design that did not toggle the watched limit would re-assert on the wrong limit or report the wrong cause. It further checks that shutdown and soft reset beat a same-cycle result, that soft reset suppresses interrupt acknowledge until the mode input is seen low, and that a negative result stays below a small positive high limit, which an unsigned compare would get wrong.

// File: rtl/thermAlertPkg.sv
package thermAlertPkg;
  localparam int MAX_FAULTS = 6;
  localparam int CNT_W = $clog2(MAX_FAULTS + 1);

  typedef struct packed {
    logic cntInc;
    logic cntClr;
  } cntStrobes_t;

  function automatic logic [CNT_W-1:0] faultNeed(input logic [1:0] code);
    case (code)
      2'd0: faultNeed = CNT_W'(1);
      2'd1: faultNeed = CNT_W'(2);
      2'd2: faultNeed = CNT_W'(4);
      default: faultNeed = CNT_W'(MAX_FAULTS);
    endcase
  endfunction
endpackage

// File: rtl/thermAlertDp.sv
module thermAlertDp
  import thermAlertPkg::*;
#(
  parameter int TEMP_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] resultTemp,
  input  logic [TEMP_W-1:0] limitLow,
  input  logic [TEMP_W-1:0] limitHigh,
  input  logic [1:0]        faultQueue,
  input  cntStrobes_t       strobes,
  output logic              atHigh,
  output logic              belowLow,
  output logic              reachNeed,
  output logic [CNT_W-1:0]  faultCnt
);
  logic [CNT_W:0]   cntPlusOne;
  logic [CNT_W-1:0] need;

  always_comb begin
    atHigh     = $signed(resultTemp) >= $signed(limitHigh);
    belowLow   = $signed(resultTemp) <  $signed(limitLow);
    need       = faultNeed(faultQueue);
    cntPlusOne = {1'b0, faultCnt} + 1'b1;
    reachNeed  = cntPlusOne >= {1'b0, need};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultCnt <= '0;
    end else if (strobes.cntClr) begin
      faultCnt <= '0;
    end else if (strobes.cntInc) begin
      if (cntPlusOne >= (CNT_W+1)'(MAX_FAULTS)) faultCnt <= CNT_W'(MAX_FAULTS);
      else faultCnt <= cntPlusOne[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/thermAlertCtl.sv
module thermAlertCtl
  import thermAlertPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        resultValid,
  input  logic        interruptMode,
  input  logic        regRead,
  input  logic        responseWon,
  input  logic        shutdownRise,
  input  logic        softReset,
  input  logic        atHigh,
  input  logic        belowLow,
  input  logic        reachNeed,
  output cntStrobes_t strobes,
  output logic        alertActive,
  output logic        alertCause,
  output logic        effInt
);
  logic watchHigh;
  logic forcedCmp;
  logic clearAck;
  logic evalOk;
  logic cond;
  logic fire;

  always_comb begin
    effInt   = interruptMode && !forcedCmp;
    clearAck = effInt && alertActive && (regRead || responseWon);
    evalOk   = resultValid && !softReset && !shutdownRise && !(effInt && alertActive);
    if (effInt) cond = watchHigh ? atHigh : belowLow;
    else        cond = alertActive ? belowLow : atHigh;
    fire = evalOk && cond && reachNeed;
    strobes.cntClr = softReset || shutdownRise || clearAck || (evalOk && (!cond || reachNeed));
    strobes.cntInc = evalOk && cond && !reachNeed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alertActive <= 1'b0;
      alertCause  <= 1'b0;
      watchHigh   <= 1'b1;
      forcedCmp   <= 1'b0;
    end else if (softReset) begin
      alertActive <= 1'b0;
      alertCause  <= 1'b0;
      watchHigh   <= 1'b1;
      forcedCmp   <= 1'b1;
    end else begin
      if (!interruptMode) forcedCmp <= 1'b0;
      if (shutdownRise) begin
        alertActive <= 1'b0;
        watchHigh   <= 1'b1;
      end else if (clearAck) begin
        alertActive <= 1'b0;
        watchHigh   <= !watchHigh;
      end else if (fire) begin
        if (effInt) begin
          alertActive <= 1'b1;
          alertCause  <= watchHigh;
        end else begin
          alertActive <= !alertActive;
          if (!alertActive) alertCause <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/thermAlert.sv
module thermAlert
  import thermAlertPkg::*;
#(
  parameter int TEMP_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resultValid,
  input  logic [TEMP_W-1:0] resultTemp,
  input  logic [TEMP_W-1:0] limitLow,
  input  logic [TEMP_W-1:0] limitHigh,
  input  logic [1:0]        faultQueue,
  input  logic              alertPolarity,
  input  logic              interruptMode,
  input  logic              regRead,
  input  logic              responseWon,
  input  logic              shutdownRise,
  input  logic              softReset,
  output logic              alertPin,
  output logic              alertCause
);
  cntStrobes_t      strobes;
  logic             atHigh;
  logic             belowLow;
  logic             reachNeed;
  logic [CNT_W-1:0] faultCnt;
  logic             alertActive;
  logic             effInt;

  thermAlertDp #(.TEMP_W(TEMP_W)) dp_i (
    .clk(clk), .rstN(rstN), .resultTemp(resultTemp), .limitLow(limitLow),
    .limitHigh(limitHigh), .faultQueue(faultQueue), .strobes(strobes),
    .atHigh(atHigh), .belowLow(belowLow), .reachNeed(reachNeed), .faultCnt(faultCnt)
  );

  thermAlertCtl ctl_i (
    .clk(clk), .rstN(rstN), .resultValid(resultValid), .interruptMode(interruptMode),
    .regRead(regRead), .responseWon(responseWon), .shutdownRise(shutdownRise),
    .softReset(softReset), .atHigh(atHigh), .belowLow(belowLow), .reachNeed(reachNeed),
    .strobes(strobes), .alertActive(alertActive), .alertCause(alertCause), .effInt(effInt)
  );

  assign alertPin = alertPolarity ? alertActive : !alertActive;
endmodule

// File: rtl/thermAlertChk.sv
module thermAlertChk
  import thermAlertPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             resultValid,
  input logic             regRead,
  input logic             responseWon,
  input logic             shutdownRise,
  input logic             softReset,
  input logic             alertActive,
  input logic             alertCause,
  input logic             effInt,
  input logic [CNT_W-1:0] faultCnt
);
  p_soft_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> !alertActive && faultCnt == '0 && !alertCause);

  p_shutdown_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    shutdownRise |=> !alertActive && faultCnt == '0);

  p_result_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid && !softReset && !shutdownRise && !regRead && !responseWon
      |=> $stable(alertActive) && $stable(faultCnt));

  p_int_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    effInt && alertActive && (regRead || responseWon) |=> !alertActive);

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    faultCnt <= CNT_W'(MAX_FAULTS));

  p_cmp_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    !effInt && !alertActive && resultValid && !softReset && !shutdownRise
      |=> !alertActive || alertCause);

  p_rise_needs_result_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alertActive) |-> $past(resultValid) && !$past(shutdownRise) && !$past(softReset));
endmodule

bind thermAlert thermAlertChk chk_i (
  .clk(clk), .rstN(rstN), .resultValid(resultValid), .regRead(regRead),
  .responseWon(responseWon), .shutdownRise(shutdownRise), .softReset(softReset),
  .alertActive(alertActive), .alertCause(alertCause), .effInt(effInt), .faultCnt(faultCnt)
);

// File: tb/thermAlert_tb_top.sv
module thermAlert_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic resultValid = 1'b0;
  logic [11:0] resultTemp = '0;
  logic [11:0] limitLow = 12'h190;
  logic [11:0] limitHigh = 12'h320;
  logic [1:0] faultQueue = 2'd0;
  logic alertPolarity = 1'b0;
  logic interruptMode = 1'b0;
  logic regRead = 1'b0;
  logic responseWon = 1'b0;
  logic shutdownRise = 1'b0;
  logic softReset = 1'b0;
  logic alertPin;
  logic alertCause;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit sweepOn = 1'b0;
  string sweepTag = "";

  // reference state built from the requirements
  bit mAct = 0, mCause = 0, mWh = 1, mForced = 0;
  int mCnt = 0;

  always #4 clk = ~clk;

  thermAlert dut_i (
    .clk(clk), .rstN(rstN), .resultValid(resultValid), .resultTemp(resultTemp),
    .limitLow(limitLow), .limitHigh(limitHigh), .faultQueue(faultQueue),
    .alertPolarity(alertPolarity), .interruptMode(interruptMode), .regRead(regRead),
    .responseWon(responseWon), .shutdownRise(shutdownRise), .softReset(softReset),
    .alertPin(alertPin), .alertCause(alertCause)
  );

  function automatic int needOf(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 6;
    endcase
  endfunction

  task automatic modelStep();
    bit effI, cond;
    effI = interruptMode && !mForced;
    if (softReset) begin
      mAct = 0; mCnt = 0; mWh = 1; mCause = 0; mForced = 1;
    end else begin
      if (!interruptMode) mForced = 0;
      if (shutdownRise) begin
        mAct = 0; mCnt = 0; mWh = 1;
      end else if (effI && mAct && (regRead || responseWon)) begin
        mAct = 0; mCnt = 0; mWh = !mWh;
      end else if (resultValid && !(effI && mAct)) begin
        if (effI) cond = mWh ? ($signed(resultTemp) >= $signed(limitHigh))
                             : ($signed(resultTemp) < $signed(limitLow));
        else cond = mAct ? ($signed(resultTemp) < $signed(limitLow))
                         : ($signed(resultTemp) >= $signed(limitHigh));
        if (!cond) mCnt = 0;
        else if (mCnt + 1 >= needOf(faultQueue)) begin
          mCnt = 0;
          if (effI) begin mAct = 1; mCause = mWh; end
          else begin
            if (!mAct) mCause = 1;
            mAct = !mAct;
          end
        end else mCnt = (mCnt + 1 > 6) ? 6 : mCnt + 1;
      end
    end
  endtask

  task automatic check(input bit expAct, input bit expCause, input bit useCause, input string tag);
    bit expPin;
    expPin = alertPolarity ? expAct : !expAct;
    checks++;
    if (alertPin !== expPin || (useCause && alertCause !== expCause)) begin
      fails++;
      $display("FAIL %s: pin=%b cause=%b expected pin=%b cause=%b", tag, alertPin, alertCause,
               expPin, expCause);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    #1;
    if (sweepOn) check(mAct, mCause, 1'b1, sweepTag);
  endtask

  task automatic res(input logic [11:0] t);
    resultValid = 1'b1; resultTemp = t;
    tick();
    resultValid = 1'b0;
  endtask

  task automatic resN(input logic [11:0] t, input int n);
    for (int i = 0; i < n; i++) res(t);
  endtask

  task automatic pulseRead();  regRead = 1'b1; tick(); regRead = 1'b0; endtask
  task automatic pulseWon();   responseWon = 1'b1; tick(); responseWon = 1'b0; endtask
  task automatic pulseSd();    shutdownRise = 1'b1; tick(); shutdownRise = 1'b0; endtask
  task automatic pulseSoft();  softReset = 1'b1; tick(); softReset = 1'b0; endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [11:0] pick [8];
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    check(1'b0, 1'b0, 1'b1, "R1 reset state");

    // R2 / R3 comparator, six-fault code
    faultQueue = 2'd3;
    resN(12'h320, 5);
    check(1'b0, 1'b0, 1'b0, "R2 five faults below code-3 threshold");
    res(12'h320);
    check(1'b1, 1'b1, 1'b1, "R2 sixth fault asserts");
    resN(12'h200, 8);
    check(1'b1, 1'b1, 1'b0, "R3 between limits holds");
    resN(12'h190, 3);
    resN(12'h18F, 5);
    check(1'b1, 1'b1, 1'b0, "R3 five below low holds, equal to low is not below");
    res(12'h18F);
    check(1'b0, 1'b0, 1'b0, "R3 sixth below low clears");

    // R4 counter reset on a broken run
    faultQueue = 2'd1;
    res(12'h320); res(12'h200); res(12'h320);
    check(1'b0, 1'b0, 1'b0, "R4 interrupted run does not assert");
    res(12'h320);
    check(1'b1, 1'b1, 1'b1, "R4 two consecutive assert");
    faultQueue = 2'd0;
    res(12'h100);
    check(1'b0, 1'b0, 1'b0, "R2 code 0 clears on one result");

    // R5 no strobe no change
    resultTemp = 12'h7FF;
    repeat (10) tick();
    check(1'b0, 1'b0, 1'b0, "R5 no comparison without strobe");

    // R8 acknowledges ignored in comparator mode
    res(12'h320);
    pulseRead(); pulseWon();
    check(1'b1, 1'b1, 1'b1, "R8 read/response ignored in comparator mode");
    res(12'h000);

    // R9 shutdown clears alert and count
    res(12'h320);
    pulseSd();
    check(1'b0, 1'b0, 1'b0, "R9 shutdown clears alert");
    faultQueue = 2'd1;
    res(12'h320); pulseSd(); res(12'h320);
    check(1'b0, 1'b0, 1'b0, "R9 shutdown clears fault count");
    res(12'h320);
    check(1'b1, 1'b1, 1'b1, "R9 count restarts after shutdown");
    faultQueue = 2'd0;
    res(12'h000);

    // R12 shutdown beats same-cycle result
    shutdownRise = 1'b1;
    res(12'h7FF);
    shutdownRise = 1'b0;
    check(1'b0, 1'b0, 1'b0, "R12 shutdown wins over same-cycle result");

    // R6 / R7 interrupt mode cycle
    interruptMode = 1'b1;
    res(12'h320);
    check(1'b1, 1'b1, 1'b1, "R6 interrupt asserts on high");
    resN(12'h000, 3);
    check(1'b1, 1'b1, 1'b1, "R6 latched despite low results");
    pulseRead();
    check(1'b0, 1'b1, 1'b0, "R6 read clears");
    res(12'h320);
    check(1'b0, 1'b1, 1'b0, "R7 high ignored while watching low");
    res(12'h18F);
    check(1'b1, 1'b0, 1'b1, "R7 low asserts with cause 0");
    pulseWon();
    check(1'b0, 1'b0, 1'b0, "R6 response won clears");
    res(12'h000);
    check(1'b0, 1'b0, 1'b0, "R7 low ignored while watching high");
    res(12'h320);
    check(1'b1, 1'b1, 1'b1, "R7 back to watching high");
    pulseRead();

    // R10 soft reset forces comparator mode
    res(12'h000);
    check(1'b1, 1'b0, 1'b1, "R7 low phase before soft reset");
    pulseSoft();
    check(1'b0, 1'b0, 1'b1, "R10 soft reset clears alert and cause");
    res(12'h320);
    check(1'b1, 1'b1, 1'b1, "R10 forced comparator asserts on high");
    pulseRead();
    check(1'b1, 1'b1, 1'b1, "R10 read ignored while forced to comparator");
    res(12'h000);
    check(1'b0, 1'b1, 1'b0, "R10 comparator clear while forced");
    interruptMode = 1'b0; tick(); interruptMode = 1'b1; tick();
    res(12'h320);
    pulseRead();
    check(1'b0, 1'b1, 1'b0, "R10 interrupt behaviour restored");

    // R11 polarity
    interruptMode = 1'b0; alertPolarity = 1'b1;
    tick();
    check(1'b0, 1'b0, 1'b0, "R11 active-high inactive level");
    res(12'h320);
    check(1'b1, 1'b1, 1'b1, "R11 active-high asserted");
    res(12'h000);
    alertPolarity = 1'b0;

    // R13 signed compare
    limitLow = 12'hE70; limitHigh = 12'h004;
    res(12'hFFC);
    check(1'b0, 1'b0, 1'b0, "R13 -0.25 below +0.25 high limit");
    res(12'h004);
    check(1'b1, 1'b1, 1'b1, "R13 equal to high asserts");
    res(12'hE70);
    check(1'b1, 1'b1, 1'b0, "R13 equal to negative low holds");
    res(12'h800);
    check(1'b0, 1'b0, 1'b0, "R13 most negative clears");

    // sweep all codes, modes and polarities against the reference
    lfsr = 16'hACE1;
    for (int cfg = 0; cfg < 16; cfg++) begin
      limitLow  = cfg[0] ? 12'hE70 : 12'h190;
      limitHigh = cfg[0] ? 12'h004 : 12'h320;
      pick[0] = limitLow - 12'd1; pick[1] = limitLow; pick[2] = limitLow + 12'd1;
      pick[3] = limitHigh - 12'd1; pick[4] = limitHigh; pick[5] = limitHigh + 12'd1;
      pick[6] = 12'h800; pick[7] = 12'h7FF;
      interruptMode = 1'b0;
      pulseSoft();
      tick();
      faultQueue = cfg[1:0] ^ cfg[3:2];
      alertPolarity = cfg[2];
      interruptMode = cfg[3];
      sweepTag = cfg[3] ? "R6 R7 R2 R4 R9 sweep interrupt" : "R3 R2 R4 R8 R9 sweep comparator";
      sweepOn = 1'b1;
      for (int n = 0; n < 400; n++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        resultTemp   = pick[lfsr[2:0]];
        resultValid  = (lfsr[4:3] != 2'b00);
        regRead      = (lfsr[7:5] == 3'b000);
        responseWon  = (lfsr[11:8] == 4'b0000);
        shutdownRise = (lfsr[15:11] == 5'b00000);
        tick();
      end
      sweepOn = 1'b0;
      resultValid = 0; regRead = 0; responseWon = 0; shutdownRise = 0;
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule